// File: doc/BRIEF.md
# Interval Timer Host Bus Interface

This block is the byte-wide host side of a programmable interval timer with several 16-bit counting channels. A host reaches it through a two-bit address, a chip select and read and write strobes. Each strobe lasts one clock cycle and takes effect at the clock edge. The low addresses reach the channels' count registers. The top address is the command register, which takes mode words, counter-latch commands and multi-channel read-back commands.

For each channel the block holds the 6-bit control value, the low/high byte order of 16-bit transfers, a frozen count snapshot and a frozen status snapshot. It hands the control value, an armed flag and each newly written count with a one-cycle load strobe to the counting engines. In return it takes each engine's live count, its output level and a pulse that marks the transfer of a loaded count into the counting element. The counting itself is not part of this block.

Top module: `tmr_bus_if`

## Requirements
- R1: After reset every channel's control value is 0x30 (both bytes, mode 0, binary), `arm_o` and `load_o` are low, and no latch is pending.
- R2: Only `addr_i[1:0]` is decoded; a read at address 3 returns 0xFF and changes no state, and a read at an address with no channel also returns 0xFF.
- R3: A write at address 3 whose bits 7:6 name a channel and whose access field (bits 5:4) is not 00 stores bits 5:0 as that channel's control value. The write resets the channel's write byte order to low and clears `arm_o` until a new count is loaded.
- R4: Count writes follow the access field: 01 replaces only the low byte, 10 only the high byte, and 11 takes the low byte and then the high byte. One cycle after the write that completes the count, `load_o` pulses for one cycle, `load_val_o` carries the count and `arm_o` is high.
- R5: A write at address 3 with access field 00 is a counter-latch command. It snapshots the live count and leaves the control value unchanged. Reads return the snapshot until it has been read out, and further count latches on that channel are ignored while it is pending.
- R6: Count reads follow the access field: 01 returns the low byte, 10 the high byte, and 11 the low byte and then the high byte. A latched count is released when its final byte is read, and later reads return the live count.
- R7: A write at address 3 with bits 7:6 = 11 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 at 0 latches the count and bit 4 at 0 latches the status of every selected channel.
- R8: The status byte has the output level in bit 7, the null-count flag in bit 6 and the control value in bits 5:0. A pending status is returned on the next read, before any latched or live count.
- R9: A status latch request on a channel that already holds an unread status is ignored; the first status stays.
- R10: Taking a count latch resets the channel's read byte order to low.
- R11: The null-count flag is set by a mode write or a completed count load, and it is cleared by the channel's `xfer_i` pulse unless it is set in the same cycle.
- R12: With `cs_i` low, reads and writes change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid during the read cycle |
| live_cnt_i | input | 16*N_CH | Live count from each engine |
| out_lvl_i | input | N_CH | Output level of each engine |
| xfer_i | input | N_CH | Pulse: the loaded count has been taken by the engine |
| ctrl_o | output | 6*N_CH | Control value of each channel |
| arm_o | output | N_CH | Channel armed with a loaded count |
| load_o | output | N_CH | One-cycle load strobe |
| load_val_o | output | 16*N_CH | Count to load |

## Verification
The assertions check on every cycle that a latched count or status stays frozen until a read of that channel, that a mode write disarms the channel and sets its null-count flag, that a load strobe only follows a count write, that address 3 reads as 0xFF and that a deselected access leaves the control values untouched. The byte ordering of 16-bit reads and writes needs the bench's scenarios. So do the priority of a status over a count, the read-order reset on a latch, the read-back channel and latch-kind selection, and an ignored second latch carrying an earlier value. The bench shows each of these against its reference model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW     = 8;
  localparam int CW     = 2 * DW;
  localparam int CTRL_W = 6;
  localparam logic [1:0] CMD_ADDR = 2'd3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_e;

  typedef struct packed {
    logic mode_wr;
    logic latch_cnt;
    logic latch_sts;
    logic data_wr;
    logic data_rd;
  } ch_cmd_t;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic                     cs_i,
  input  logic                     rd_i,
  input  logic                     wr_i,
  input  logic [1:0]               addr_i,
  input  logic [DW-1:0]            wdata_i,
  output ch_cmd_t [N_CH-1:0]       cmd_o
);
  logic cmd_wr, rb;
  assign cmd_wr = cs_i && wr_i && (addr_i == CMD_ADDR);
  assign rb     = cmd_wr && (wdata_i[7:6] == 2'b11);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic tgt, sel, rb_sel;
    assign sel    = cs_i && (addr_i == 2'(i));
    assign tgt    = cmd_wr && !rb && (wdata_i[7:6] == 2'(i));
    assign rb_sel = rb && wdata_i[1+i];
    assign cmd_o[i].mode_wr   = tgt && (wdata_i[5:4] != ACC_LATCH);
    assign cmd_o[i].latch_cnt = (tgt && (wdata_i[5:4] == ACC_LATCH)) || (rb_sel && !wdata_i[5]);
    assign cmd_o[i].latch_sts = rb_sel && !wdata_i[4];
    assign cmd_o[i].data_wr   = sel && wr_i;
    assign cmd_o[i].data_rd   = sel && rd_i && !wr_i;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ch_cmd_t           cmd_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [CW-1:0]     live_i,
  input  logic              out_i,
  input  logic              xfer_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              arm_o,
  output logic              load_o,
  output logic [CW-1:0]     load_val_o,
  output logic [DW-1:0]     rdata_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              null_q, wr_hi_q, rd_hi_q, cl_v_q, sts_v_q, arm_q, load_q;
  logic [DW-1:0]     wbuf_q, sts_q;
  logic [CW-1:0]     cl_q, lval_q;
  logic [CW-1:0]     src;
  acc_e              acc;

  assign acc = acc_e'(ctrl_q[5:4]);
  assign src = cl_v_q ? cl_q : live_i;

  always_comb begin
    if (sts_v_q) rdata_o = sts_q;
    else begin
      unique case (acc)
        ACC_HI:   rdata_o = src[CW-1:DW];
        ACC_BOTH: rdata_o = rd_hi_q ? src[CW-1:DW] : src[DW-1:0];
        default:  rdata_o = src[DW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= 6'h30;
      null_q  <= 1'b0;
      wr_hi_q <= 1'b0;
      rd_hi_q <= 1'b0;
      cl_v_q  <= 1'b0;
      sts_v_q <= 1'b0;
      arm_q   <= 1'b0;
      load_q  <= 1'b0;
      wbuf_q  <= '0;
      sts_q   <= '0;
      cl_q    <= '0;
      lval_q  <= '0;
    end else begin
      load_q <= 1'b0;
      if (xfer_i) null_q <= 1'b0;
      if (cmd_i.mode_wr) begin
        ctrl_q  <= wdata_i[CTRL_W-1:0];
        wr_hi_q <= 1'b0;
        arm_q   <= 1'b0;
        null_q  <= 1'b1;
      end
      if (cmd_i.latch_cnt && !cl_v_q) begin
        cl_v_q  <= 1'b1;
        cl_q    <= live_i;
        rd_hi_q <= 1'b0;
      end
      if (cmd_i.latch_sts && !sts_v_q) begin
        sts_v_q <= 1'b1;
        sts_q   <= {out_i, null_q, ctrl_q};
      end
      if (cmd_i.data_wr) begin
        unique case (acc)
          ACC_HI: begin
            lval_q <= {wdata_i, lval_q[DW-1:0]};
            load_q <= 1'b1; arm_q <= 1'b1; null_q <= 1'b1;
          end
          ACC_BOTH: begin
            if (!wr_hi_q) begin
              wbuf_q  <= wdata_i;
              wr_hi_q <= 1'b1;
            end else begin
              lval_q  <= {wdata_i, wbuf_q};
              wr_hi_q <= 1'b0;
              load_q <= 1'b1; arm_q <= 1'b1; null_q <= 1'b1;
            end
          end
          default: begin
            lval_q <= {lval_q[CW-1:DW], wdata_i};
            load_q <= 1'b1; arm_q <= 1'b1; null_q <= 1'b1;
          end
        endcase
      end
      if (cmd_i.data_rd) begin
        if (sts_v_q) sts_v_q <= 1'b0;
        else if (acc == ACC_BOTH && !rd_hi_q) rd_hi_q <= 1'b1;
        else begin
          rd_hi_q <= 1'b0;
          cl_v_q  <= 1'b0;
        end
      end
    end
  end

  assign ctrl_o     = ctrl_q;
  assign arm_o      = arm_q;
  assign load_o     = load_q;
  assign load_val_o = lval_q;

  // R3
  mode_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.mode_wr |=> (!arm_o && ctrl_o == $past(wdata_i[CTRL_W-1:0])));
  // R11
  mode_null_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.mode_wr |=> null_q);
  // R4
  load_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(cmd_i.data_wr));
  // R5
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_v_q && !cmd_i.data_rd) |=> (cl_v_q && $stable(cl_q)));
  // R9
  sts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_v_q && !cmd_i.data_rd) |=> (sts_v_q && $stable(sts_q)));
endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
  import tmr_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_i,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic [1:0]             addr_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             rdata_o,
  input  logic [16*N_CH-1:0]     live_cnt_i,
  input  logic [N_CH-1:0]        out_lvl_i,
  input  logic [N_CH-1:0]        xfer_i,
  output logic [6*N_CH-1:0]      ctrl_o,
  output logic [N_CH-1:0]        arm_o,
  output logic [N_CH-1:0]        load_o,
  output logic [16*N_CH-1:0]     load_val_o
);
  ch_cmd_t [N_CH-1:0]  cmd;
  logic [DW-1:0]       ch_rd [N_CH];

  tmr_cmd_decode #(.N_CH(N_CH)) u_dec (
    .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cmd_o(cmd)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    tmr_chan u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd[i]), .wdata_i(wdata_i),
      .live_i(live_cnt_i[CW*i +: CW]), .out_i(out_lvl_i[i]), .xfer_i(xfer_i[i]),
      .ctrl_o(ctrl_o[CTRL_W*i +: CTRL_W]), .arm_o(arm_o[i]), .load_o(load_o[i]),
      .load_val_o(load_val_o[CW*i +: CW]), .rdata_o(ch_rd[i])
    );
  end

  always_comb begin
    rdata_o = 8'hFF;
    for (int i = 0; i < N_CH; i++)
      if (addr_i == 2'(i)) rdata_o = ch_rd[i];
  end

  // R2
  cmd_rd_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i == CMD_ADDR) |-> (rdata_o == 8'hFF));
  // R12
  desel_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> $stable(ctrl_o));
endmodule

// File: tb/tb_tmr_bus_if.sv
`timescale 1ns/1ps
module tb_tmr_bus_if;
  localparam int N = 3;
  logic clk = 0, rst_n = 0;
  logic cs = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wd = 0, rdata;
  logic [15:0] live [N];
  logic [N-1:0] outl = 0, xfer = 0;
  logic [6*N-1:0] ctrl;
  logic [N-1:0] arm, load;
  logic [16*N-1:0] lval;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_bus_if #(.N_CH(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wd), .rdata_o(rdata),
    .live_cnt_i({live[2], live[1], live[0]}), .out_lvl_i(outl), .xfer_i(xfer),
    .ctrl_o(ctrl), .arm_o(arm), .load_o(load), .load_val_o(lval)
  );

  // reference model state
  int m_ctrl[N], m_arm[N], m_nul[N], m_wrhi[N], m_wbuf[N], m_lval[N], m_ld[N];
  int m_rdhi[N], m_clv[N], m_cl[N], m_sv[N], m_st[N];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_peek(int a);
    int s;
    if (a >= N) return 8'hFF;
    if (m_sv[a]) return m_st[a];
    s = m_clv[a] ? m_cl[a] : int'(live[a]);
    case ((m_ctrl[a] >> 4) & 3)
      2: return (s >> 8) & 8'hFF;
      3: return m_rdhi[a] ? ((s >> 8) & 8'hFF) : (s & 8'hFF);
      default: return s & 8'hFF;
    endcase
  endfunction

  task automatic m_latch_cnt(int i);
    if (!m_clv[i]) begin m_clv[i] = 1; m_cl[i] = int'(live[i]); m_rdhi[i] = 0; end
  endtask

  task automatic m_apply(bit c, bit r, bit w, int a, int d);
    for (int i = 0; i < N; i++) m_ld[i] = 0;
    if (c && w && a == 3) begin
      if (((d >> 6) & 3) == 3) begin
        for (int i = 0; i < N; i++)
          if ((d >> (1 + i)) & 1) begin
            if (!((d >> 5) & 1)) m_latch_cnt(i);
            if (!((d >> 4) & 1) && !m_sv[i]) begin
              m_sv[i] = 1;
              m_st[i] = (int'(outl[i]) << 7) | (m_nul[i] << 6) | m_ctrl[i];
            end
          end
      end
    end
    for (int i = 0; i < N; i++) if (xfer[i]) m_nul[i] = 0;
    if (c && w && a == 3 && ((d >> 6) & 3) < N) begin
      int t = (d >> 6) & 3;
      if (((d >> 4) & 3) == 0) m_latch_cnt(t);
      else begin m_ctrl[t] = d & 8'h3F; m_wrhi[t] = 0; m_arm[t] = 0; m_nul[t] = 1; end
    end
    if (c && w && a < N) begin
      int acc = (m_ctrl[a] >> 4) & 3;
      bit done_ld = 1;
      if (acc == 2) m_lval[a] = (d << 8) | (m_lval[a] & 8'hFF);
      else if (acc == 3) begin
        if (!m_wrhi[a]) begin m_wbuf[a] = d; m_wrhi[a] = 1; done_ld = 0; end
        else begin m_lval[a] = (d << 8) | m_wbuf[a]; m_wrhi[a] = 0; end
      end else m_lval[a] = (m_lval[a] & 16'hFF00) | d;
      if (done_ld) begin m_ld[a] = 1; m_arm[a] = 1; m_nul[a] = 1; end
    end
    if (c && r && !w && a < N) begin
      if (m_sv[a]) m_sv[a] = 0;
      else if (((m_ctrl[a] >> 4) & 3) == 3 && !m_rdhi[a]) m_rdhi[a] = 1;
      else begin m_rdhi[a] = 0; m_clv[a] = 0; end
    end
  endtask

  task automatic cmp_all();
    for (int i = 0; i < N; i++) begin
      chk("R3 ctrl", int'(ctrl[6*i +: 6]), m_ctrl[i]);
      chk("R4 arm", int'(arm[i]), m_arm[i]);
      chk("R4 load", int'(load[i]), m_ld[i]);
      chk("R4 load_val", int'(lval[16*i +: 16]), m_lval[i]);
    end
  endtask

  task automatic step(bit c, bit r, bit w, int a, int d, string tag);
    @(negedge clk);
    cs = c; rd = r; wr = w; addr = 2'(a); wd = 8'(d);
    #1;
    if (c && r) chk(tag, int'(rdata), m_peek(a));
    @(posedge clk); #1;
    m_apply(c, r, w, a, d);
    cmp_all();
    @(negedge clk);
    cs = 0; rd = 0; wr = 0; xfer = 0;
  endtask

  task automatic wr_(int a, int d, string tag); step(1, 0, 1, a, d, tag); endtask
  task automatic rd_(int a, string tag);        step(1, 1, 0, a, 0, tag); endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      live[i] = 16'h0;
      m_ctrl[i] = 8'h30; m_arm[i] = 0; m_nul[i] = 0; m_wrhi[i] = 0; m_wbuf[i] = 0;
      m_lval[i] = 0; m_ld[i] = 0; m_rdhi[i] = 0; m_clv[i] = 0; m_cl[i] = 0;
      m_sv[i] = 0; m_st[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1; cmp_all();                          // R1 reset state
    @(negedge clk); rst_n = 1;
    rd_(3, "R2 cmd read FF");               // R2
    rd_(3, "R2 cmd read FF again");
    // R4 both-byte write on channel 0
    wr_(0, 8'h34, "R4");
    wr_(0, 8'h12, "R4");
    step(0, 0, 0, 0, 0, "R4 idle");
    // R3 mode write ch1 low-only, then R4 low and high only
    wr_(3, 8'h50, "R3");
    wr_(1, 8'hAB, "R4 lo only");
    wr_(3, 8'h60, "R3");
    wr_(1, 8'hCD, "R4 hi only");
    // R11 null flag via status, before and after xfer; R7 R8 status read-back
    outl = 3'b010;
    wr_(3, 8'hE4, "R7");
    rd_(1, "R8 status ch1 null set");
    xfer = 3'b010;
    step(0, 0, 0, 0, 0, "R11 xfer");
    wr_(3, 8'hE4, "R7");
    rd_(1, "R11 status ch1 null clear");
    // R5 counter latch on ch0, ignored relatch, then R6 release
    live[0] = 16'h5678;
    wr_(3, 8'h00, "R5");
    live[0] = 16'h1111;
    wr_(3, 8'h00, "R5 relatch ignored");
    rd_(0, "R5 latched lo");
    rd_(0, "R6 latched hi");
    rd_(0, "R6 live lo after release");
    rd_(0, "R6 live hi");
    // R7 R8 status and count on ch2
    wr_(3, 8'hB2, "R3 ch2");
    live[2] = 16'hBEEF; outl = 3'b100;
    wr_(3, 8'hC8, "R7 both latches");
    live[2] = 16'h0000; outl = 3'b000;
    rd_(2, "R8 status first");
    rd_(2, "R7 count lo");
    rd_(2, "R7 count hi");
    // R9 second status ignored
    outl = 3'b001;
    wr_(3, 8'hE2, "R9");
    outl = 3'b000;
    wr_(3, 8'hE2, "R9 ignored");
    rd_(0, "R9 first status kept");
    rd_(0, "R9 then live");
    rd_(0, "R9 live hi");
    // R10 latch resets read order
    live[0] = 16'hA1B2;
    rd_(0, "R10 lo");
    wr_(3, 8'h00, "R10 latch");
    live[0] = 16'h0;
    rd_(0, "R10 lo after latch");
    rd_(0, "R10 hi after latch");
    // R6 low-only reads do not alternate
    wr_(3, 8'h10, "R3 ch0 lo");
    live[0] = 16'hC3D4;
    rd_(0, "R6 lo only");
    rd_(0, "R6 lo only again");
    wr_(3, 8'h20, "R3 ch0 hi");
    rd_(0, "R6 hi only");
    // R12 deselected accesses have no effect
    step(0, 0, 1, 3, 8'h5A, "R12");
    step(0, 0, 1, 0, 8'h77, "R12");
    step(0, 1, 0, 0, 0, "R12");
    wr_(3, 8'hE2, "R12 status probe");
    rd_(0, "R12 ch0 status unchanged");
    rd_(3, "R2 final");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule